// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block is the serial core of an SPI master. It performs one transfer at a time: a parallel transmit word is shifted out on MOSI while MISO is collected into a parallel receive word. The transfer length can be set anywhere from one bit up to the full data width. The bit order is selectable. All four combinations of clock polarity and clock phase are supported. SCLK comes from a fixed divider of the system clock.

Configuration arrives as a single write strobe that carries an enable bit and the mode fields together. While the engine is enabled, the mode fields are frozen. A transfer starts when a transmit write arrives while the engine is enabled and idle. The word on the parallel side is always right-aligned: its least significant bit sits at bit 0 whatever the bit order on the wire. Unused upper receive bits read as zero.

Top module: `spi_shift_master`

## Requirements
- R1: `cfg_len_m1` holds the length minus one, so a value of n selects n+1 bits. Each transfer shifts exactly that many bits and produces exactly that many SCLK pulses, which is twice that many SCLK transitions.
- R2: When the length is below the data width, `rx_data` bits at and above the length read as zero.
- R3: With `cfg_lsb_first`=0, word bit length-1 is transferred first and bit 0 last. With `cfg_lsb_first`=1, bit 0 is transferred first. The same order applies to MOSI and to MISO, and both parallel words keep bit 0 as the least significant bit.
- R4: Whenever no transfer is running, SCLK rests at the polarity bit: low when it is 0, high when it is 1.
- R5: With phase 0, MOSI carries the first bit from the start cycle onward, and MISO is sampled on the first, third and later odd SCLK transitions. With phase 1, each bit is driven on an odd transition and sampled on the following even transition.
- R6: The k-th SCLK transition of a transfer occurs k*DIV_HALF system clocks after the clock edge that accepted the transmit write.
- R7: On a configuration write, the mode fields (polarity, phase, bit order, length) are updated only when the engine is currently disabled and the write also leaves it disabled. The enable bit always takes the written value.
- R8: A transmit write starts a transfer only while the engine is enabled and not busy. A write at any other time is ignored and leaves the transfer in progress unchanged.
- R9: `busy` rises on the clock edge that accepts the transmit write. `rx_valid` is high for exactly one system clock, one cycle after the final SCLK transition, and `busy` falls on that same edge.
- R10: `rx_data` holds its value between completions.
- R11: After reset, `busy`, `rx_valid`, `rx_data`, `mosi` and `sclk` are all zero. The engine is disabled in mode 0, MSB first, at full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value written by the strobe |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Sampling phase |
| cfg_lsb_first | input | 1 | 1: bit 0 first on the wire |
| cfg_len_m1 | input | $clog2(DATA_W) | Transfer length minus one |
| tx_data | input | DATA_W | Transmit word, right-aligned |
| tx_wr | input | 1 | Transmit write; starts a transfer |
| rx_data | output | DATA_W | Receive word, right-aligned, zero-padded |
| rx_valid | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume a slave that is well behaved in time. MISO is assumed stable around every sampling edge, and the transmit word only needs to be valid in the cycle of an accepted write. The idle-level property also assumes that the mode is not rewritten in the same cycle a transfer ends, so it is checked only after the mode has been steady for a cycle. The stimulus respects these limits. MISO changes only at falling system-clock edges, and only at the offset where the bench's own slave model moves to the next bit. Random configurations always go through a disabled write followed by an enabling write, so mode updates never race a running transfer.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  localparam int SPI_MAXW = 32;
  localparam int SPI_IW   = 5;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              lsb_first;
    logic [SPI_IW-1:0] len_m1;
  } spi_mode_t;

  // Word position of the serial bit with index idx.
  function automatic logic [SPI_IW-1:0] bit_pos(input logic [SPI_IW-1:0] idx,
                                                input logic [SPI_IW-1:0] len_m1,
                                                input logic lsb_first);
    return lsb_first ? idx : SPI_IW'(len_m1 - idx);
  endfunction

  // Ones in the low len_m1+1 bits.
  function automatic logic [SPI_MAXW-1:0] len_mask(input logic [SPI_IW-1:0] len_m1);
    logic [SPI_MAXW:0] t;
    t = ({{SPI_MAXW{1'b0}}, 1'b1} << (6'(len_m1) + 6'd1)) - 33'd1;
    return t[SPI_MAXW-1:0];
  endfunction

endpackage

// File: rtl/spi_cfg_lock.sv
module spi_cfg_lock
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we,
  input  logic      cfg_en,
  input  spi_mode_t cfg_mode,
  output logic      en_q,
  output spi_mode_t mode_q,
  output logic      mode_upd
);

  localparam logic [SPI_IW-1:0] RST_LEN_M1 = SPI_IW'(DATA_W - 1);

  // Mode fields move only while disabled, and not when the write also enables.
  assign mode_upd = cfg_we && !en_q && !cfg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q          <= 1'b0;
      mode_q.cpol   <= 1'b0;
      mode_q.cpha   <= 1'b0;
      mode_q.lsb_first <= 1'b0;
      mode_q.len_m1 <= RST_LEN_M1;
    end else begin
      if (cfg_we) en_q <= cfg_en;
      if (mode_upd) mode_q <= cfg_mode;
    end
  end

endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  spi_mode_t         mode_in,
  input  logic              tick,
  input  logic              miso,
  output logic              run,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid,
  output spi_mode_t         xfer_mode,
  output logic [SPI_MAXW-1:0] tx_hold,
  output logic              sample_evt,
  output logic              drive_evt
);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FIN} st_t;

  st_t                 st_q;
  spi_mode_t           xm_q;
  logic [SPI_MAXW-1:0] tx_q;
  logic [SPI_MAXW-1:0] rx_acc_q;
  logic [SPI_IW-1:0]   idx_q;
  logic [SPI_IW:0]     ecnt_q;
  logic                sclk_q;
  logic                mosi_q;
  logic [DATA_W-1:0]   rx_q;
  logic                rx_valid_q;

  logic                leading;
  logic                last_edge;
  logic [SPI_IW-1:0]   nidx;
  logic [SPI_MAXW-1:0] tx_wide;
  logic                first_bit;

  assign tx_wide   = SPI_MAXW'(tx_word) & len_mask(mode_in.len_m1);
  assign first_bit = tx_wide[bit_pos('0, mode_in.len_m1, mode_in.lsb_first)];

  assign leading    = ~ecnt_q[0];
  assign last_edge  = (ecnt_q == {xm_q.len_m1, 1'b1});
  assign sample_evt = tick && (xm_q.cpha ? !leading : leading);
  assign drive_evt  = tick && (xm_q.cpha ? leading : (!leading && !last_edge));
  assign nidx       = (xm_q.cpha && ecnt_q == '0) ? '0 : SPI_IW'(idx_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      xm_q       <= '0;
      tx_q       <= '0;
      rx_acc_q   <= '0;
      idx_q      <= '0;
      ecnt_q     <= '0;
      sclk_q     <= 1'b0;
      mosi_q     <= 1'b0;
      rx_q       <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          sclk_q <= mode_in.cpol;
          if (start) begin
            st_q     <= ST_SHIFT;
            xm_q     <= mode_in;
            tx_q     <= tx_wide;
            rx_acc_q <= '0;
            idx_q    <= '0;
            ecnt_q   <= '0;
            mosi_q   <= mode_in.cpha ? 1'b0 : first_bit;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            ecnt_q <= ecnt_q + 1'b1;
            if (sample_evt)
              rx_acc_q[bit_pos(idx_q, xm_q.len_m1, xm_q.lsb_first)] <= miso;
            if (drive_evt) begin
              idx_q  <= nidx;
              mosi_q <= tx_q[bit_pos(nidx, xm_q.len_m1, xm_q.lsb_first)];
            end
            if (last_edge) st_q <= ST_FIN;
          end
        end
        default: begin
          rx_q       <= rx_acc_q[DATA_W-1:0];
          rx_valid_q <= 1'b1;
          sclk_q     <= xm_q.cpol;
          st_q       <= ST_IDLE;
        end
      endcase
    end
  end

  assign run       = (st_q == ST_SHIFT);
  assign busy      = (st_q != ST_IDLE);
  assign sclk      = sclk_q;
  assign mosi      = mosi_q;
  assign rx_word   = rx_q;
  assign rx_valid  = rx_valid_q;
  assign xfer_mode = xm_q;
  assign tx_hold   = tx_q;

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_eng_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DIV_HALF = 2,
  localparam int LEN_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  spi_mode_t           cfg_mode;
  spi_mode_t           mode_q;
  spi_mode_t           xfer_mode;
  logic                en_q;
  logic                mode_upd;
  logic                tick;
  logic                run;
  logic                start_evt;
  logic                sample_evt;
  logic                drive_evt;
  logic [SPI_MAXW-1:0] tx_hold;
  logic                mode_cpol;
  logic [SPI_IW-1:0]   xfer_len_m1;

  assign cfg_mode.cpol      = cfg_cpol;
  assign cfg_mode.cpha      = cfg_cpha;
  assign cfg_mode.lsb_first = cfg_lsb_first;
  assign cfg_mode.len_m1    = SPI_IW'(cfg_len_m1);

  assign start_evt   = tx_wr && en_q && !busy;
  assign mode_cpol   = mode_q.cpol;
  assign xfer_len_m1 = xfer_mode.len_m1;

  spi_cfg_lock #(.DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_en   (cfg_en),
    .cfg_mode (cfg_mode),
    .en_q     (en_q),
    .mode_q   (mode_q),
    .mode_upd (mode_upd)
  );

  spi_sclk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .tx_word    (tx_data),
    .mode_in    (mode_q),
    .tick       (tick),
    .miso       (miso),
    .run        (run),
    .busy       (busy),
    .sclk       (sclk),
    .mosi       (mosi),
    .rx_word    (rx_data),
    .rx_valid   (rx_valid),
    .xfer_mode  (xfer_mode),
    .tx_hold    (tx_hold),
    .sample_evt (sample_evt),
    .drive_evt  (drive_evt)
  );

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                rx_valid,
  input logic [DATA_W-1:0]   rx_data,
  input logic                sclk,
  input logic                en_q,
  input logic                mode_cpol,
  input logic                mode_upd,
  input logic                tx_wr,
  input logic [SPI_IW-1:0]   xfer_len_m1,
  input logic [SPI_MAXW-1:0] tx_hold
);

  logic [SPI_MAXW-1:0] rx_wide;
  assign rx_wide = SPI_MAXW'(rx_data);

  // R2: no bit at or above the transfer length survives into the receive word
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_wide & ~len_mask(xfer_len_m1)) == '0));

  // R4: resting clock level follows polarity once the mode has settled
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(mode_cpol)) |-> (sclk == mode_cpol));

  // R7: no mode change while enabled
  a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> !mode_upd);

  a_r7_cpol_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(mode_cpol));

  // R8: the held transmit word cannot be replaced mid-transfer
  a_r8_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr) |=> (!busy || $stable(tx_hold)));

  // R9: completion pulse is one cycle wide and ends busy
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!busy && $past(busy)));

  // R10: receive word only moves with the completion pulse
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

endmodule

bind spi_shift_master spi_eng_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .sclk        (sclk),
  .en_q        (en_q),
  .mode_cpol   (mode_cpol),
  .mode_upd    (mode_upd),
  .tx_wr       (tx_wr),
  .xfer_len_m1 (xfer_len_m1),
  .tx_hold     (tx_hold)
);

// File: tb/sim_spi_shift_master.sv
module sim_spi_shift_master;

  localparam int DW = 16;
  localparam int DH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [3:0]    cfg_len_m1 = 4'd0;
  logic [DW-1:0] tx_data = '0;
  logic          tx_wr = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_valid, busy, sclk, mosi;
  logic          miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit m_en = 0, m_cpol = 0, m_cpha = 0, m_lsb = 0;
  int m_len = DW;

  always #2.5 clk = ~clk;

  spi_shift_master #(.DATA_W(DW), .DIV_HALF(DH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first), .cfg_len_m1(cfg_len_m1),
    .tx_data(tx_data), .tx_wr(tx_wr), .rx_data(rx_data), .rx_valid(rx_valid),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic int epos(int i, int len, bit lsb);
    return lsb ? i : len - 1 - i;
  endfunction

  function automatic logic [DW-1:0] emask(int len);
    logic [DW-1:0] m = '0;
    for (int i = 0; i < len; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(bit en, bit cpol, bit cpha, bit lsb, int len);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_lsb_first = lsb; cfg_len_m1 = 4'(len - 1);
    @(negedge clk);
    cfg_we = 0;
    if (!m_en && !en) begin
      m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_len = len;
    end
    m_en = en;
  endtask

  task automatic xfer(logic [DW-1:0] txw, logic [DW-1:0] slw, bit spur, string tag);
    int len = m_len;
    int tot = 2 * len * DH;
    logic [DW-1:0] got = '0;
    logic [DW-1:0] held;
    int bad_clk = 0;
    int bad_hs = 0;
    @(negedge clk);
    tx_data = txw; tx_wr = 1;
    @(negedge clk);
    tx_wr = 0;
    for (int c = 0; c <= tot + 1; c++) begin
      int k = c / DH;
      int kk = (k > 2 * len) ? 2 * len : k;
      int mi = m_cpha ? ((k == 0) ? 0 : (k - 1) / 2) : k / 2;
      if (mi > len - 1) mi = len - 1;
      miso = slw[epos(mi, len, m_lsb)];
      if (sclk !== (m_cpol ^ (kk % 2 == 1))) bad_clk++;
      if (c <= tot) begin
        if (busy !== 1'b1 || rx_valid !== 1'b0) bad_hs++;
      end else if (busy !== 1'b0 || rx_valid !== 1'b1) bad_hs++;
      tx_wr = spur && (c == 3);
      if (spur) tx_data = ~txw;
      if (((c + 1) % DH) == 0) begin
        int k1 = (c + 1) / DH;
        if (k1 >= 1 && k1 <= 2 * len && ((k1 % 2 == 1) != m_cpha)) begin
          int bi = m_cpha ? (k1 / 2 - 1) : ((k1 - 1) / 2);
          got[epos(bi, len, m_lsb)] = mosi;
        end
      end
      if (c == tot + 1) begin
        chk(rx_data === (slw & emask(len)), {tag, " R3 R5 rx word"}, 32'(rx_data), 32'(slw & emask(len)));
        chk((rx_data & ~emask(len)) == '0, {tag, " R2 upper zero"}, 32'(rx_data), 32'(slw & emask(len)));
      end
      @(negedge clk);
    end
    chk(got === (txw & emask(len)), {tag, " R3 R5 mosi word"}, 32'(got), 32'(txw & emask(len)));
    chk(bad_clk == 0, {tag, " R1 R4 R6 sclk timing"}, 32'(bad_clk), 0);
    chk(bad_hs == 0, {tag, spur ? " R8 R9 busy/valid" : " R9 busy/valid"}, 32'(bad_hs), 0);
    held = rx_data;
    @(negedge clk);
    chk(rx_valid === 1'b0 && rx_data === held, {tag, " R10 hold"}, 32'(rx_data), 32'(held));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(busy === 0 && rx_valid === 0, "R11 busy/valid", {30'd0, busy, rx_valid}, 0);
    chk(rx_data === '0 && mosi === 0 && sclk === 0, "R11 data/lines", {14'd0, rx_data, mosi, sclk}, 0);

    // R8: write while disabled is ignored
    @(negedge clk); tx_data = 16'hA5A5; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    repeat (4) @(negedge clk);
    chk(busy === 0 && sclk === 0, "R8 disabled write", {30'd0, busy, sclk}, 0);

    // directed: every mode at full length, plus short lengths, both orders
    for (int md = 0; md < 4; md++) begin
      cfg_wr(0, md[1], md[0], 0, 16);
      cfg_wr(1, md[1], md[0], 0, 16);
      xfer(16'hC3A1, 16'h5E72, 0, "dir full msb");
      cfg_wr(0, md[1], md[0], 1, 1);
      cfg_wr(1, md[1], md[0], 1, 1);
      xfer(16'hFFFF, 16'hFFFF, 0, "dir len1 lsb");
      cfg_wr(0, md[1], md[0], 1, 7);
      cfg_wr(1, md[1], md[0], 1, 7);
      xfer(16'h0F4B, 16'hFF29, 0, "dir len7 lsb");
    end

    // R7 lockout
    cfg_wr(0, 0, 0, 0, 8);
    cfg_wr(1, 0, 0, 0, 8);
    cfg_wr(1, 1, 1, 1, 4);
    @(negedge clk);
    chk(sclk === 0, "R7 write while enabled", 32'(sclk), 0);
    xfer(16'h00B6, 16'h0091, 0, "R7 mode kept");
    cfg_wr(0, 1, 1, 1, 4);
    @(negedge clk);
    chk(sclk === 0, "R7 write that disables", 32'(sclk), 0);
    cfg_wr(0, 1, 1, 1, 4);
    @(negedge clk);
    chk(sclk === 1, "R7 R4 write while disabled", 32'(sclk), 1);
    cfg_wr(1, 1, 1, 1, 4);
    xfer(16'h000D, 16'h0006, 1, "R8 spurious write");

    // random mix
    for (int it = 0; it < 120; it++) begin
      bit p = 1'($urandom);
      bit h = 1'($urandom);
      bit o = 1'($urandom);
      int l = 1 + int'($urandom % 16);
      cfg_wr(0, p, h, o, l);
      cfg_wr(1, p, h, o, l);
      xfer(16'($urandom), 16'($urandom), (it % 10) == 0, "rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule